// File: doc/BRIEF.md
# Quadrature and Index Output Generator

The block converts a stream of single-step angle moves, produced by an upstream sine-to-digital converter, into incremental encoder outputs. It drives two quadrature tracks, A and B, and a gated index track, Z. Each of the three tracks comes with its inverted copy. Steps arrive as one-cycle up or down pulses. They are collected in a signed backlog counter and released as quadrature edges. Two released edges are never closer together than a programmable minimum phase distance. This lets a downstream counter tolerate bursts of steps that arrive faster than it can count.

The index track has three qualifiers, and Z is high only when all three agree:
- A one-hot selection of one of the four A/B quadrants.
- A count of A/B periods. The count restarts at the sine zero-crossing marker and wraps at the configured interpolation factor.
- An external zero-track enable.

The interpolation factor is one of 1, 2, 4, 5, 10, 20, 25 and 50. One input period spans four quadrature states per factor unit.

Top module: `quad_index_gen`

## Requirements
- R1: While reset is active and right after reset, A, B and Z are low and their complements are high. The overflow flag is low, and the A/B period counter is zero.
- R2: An up step advances the A/B state through 00, 10, 11, 01 (written AB), so A leads B. A down step walks that sequence backwards. A and B never change in the same cycle.
- R3: NA, NB and NZ are always the inverse of A, B and Z.
- R4: With a backlog of steps, successive A/B edges are spaced exactly M = (code - 7) x CYC_PER_200NS clock cycles apart, for a 4-bit distance code from 8 to 15. Codes 0 to 7 behave as code 8. A change of the index register is also held to this spacing.
- R5: Steps that arrive faster than the spacing allows are queued, and none is lost below saturation. Opposite steps cancel in the queue, so after draining, the A/B state reflects the net step count.
- R6: The backlog is a signed 8-bit count that saturates at +127 and -128. A step that would pass a limit is dropped and sets a sticky overflow flag, which only reset clears.
- R7: The factor select uses codes 0 to 7 for factors 1, 2, 4, 5, 10, 20, 25 and 50. The period counter advances on the AB 01 to 00 transition going up. It retreats on the 00 to 01 transition going down, and it wraps modulo the factor.
- R8: Quadrant select bit 3 picks AB=11, bit 2 picks AB=10, bit 1 picks AB=00, and bit 0 picks AB=01. Z is high only in a selected quadrant.
- R9: Index position bit 7 enables the index. Bits 6:0 name the period, counted from the last sine zero marker, in which Z may be high. With bit 7 clear, Z stays low.
- R10: If the index position bits 6:0 are greater than or equal to the factor, Z is never asserted.
- R11: Z is high only while the zero-track enable input is high. Dropping the enable forces Z low at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stepValid | input | 1 | One angle step this cycle |
| stepDir | input | 1 | Step direction, 1 = up |
| sineZero | input | 1 | Sine zero-crossing marker, restarts the period count |
| zeroEn | input | 1 | Digitized zero-track enable |
| factorSel | input | 3 | Interpolation factor code |
| quadSel | input | 4 | One-hot index quadrant select |
| idxPos | input | 8 | Bit 7 index enable, bits 6:0 index period |
| mtdCode | input | 4 | Minimum phase distance code |
| outA | output | 1 | Quadrature track A |
| outNA | output | 1 | Inverse of A |
| outB | output | 1 | Quadrature track B |
| outNB | output | 1 | Inverse of B |
| outZ | output | 1 | Index track |
| outNZ | output | 1 | Inverse of Z |
| overflow | output | 1 | Sticky backlog saturation flag |

## Verification
The bench sweeps every factor with the index set at the first period, at the last period, just past the last period, and with the index disabled. It checks Z after each single up step, and after down steps across the backward period wrap. An off-by-one in the period wrap would move the pulse to a neighbouring period or show it when the position equals the factor. A wrong quadrant map would move the pulse within the period. Edge spacing is measured under a five-step burst for the shortest code, a mid code, the longest code and an illegal code; a wrong reload shows up as a gap one or more cycles off. A 200-step burst at the longest spacing drives the backlog into saturation. A counter that wrapped instead of clamping, or that lost the steps arriving in the same cycle as a release, would leave a different total edge count and final A/B state.

// File: rtl/qig_pkg.sv
`timescale 1ns/1ps
package qig_pkg;

  // strobes from the control to the datapath
  typedef struct packed {
    logic emit;   // release one quadrature step
    logic up;     // direction of the released step
    logic zLoad;  // refresh the index register without a step
  } strobe_t;

  function automatic logic [6:0] factorOf(input logic [2:0] sel);
    case (sel)
      3'd0:    return 7'd1;
      3'd1:    return 7'd2;
      3'd2:    return 7'd4;
      3'd3:    return 7'd5;
      3'd4:    return 7'd10;
      3'd5:    return 7'd20;
      3'd6:    return 7'd25;
      default: return 7'd50;
    endcase
  endfunction

endpackage

// File: rtl/qig_ctrl.sv
`timescale 1ns/1ps
module qig_ctrl
  import qig_pkg::*;
#(
  parameter int PEND_W        = 8,
  parameter int CYC_PER_200NS = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepValid,
  input  logic       stepDir,
  input  logic [3:0] mtdCode,
  input  logic       zDiffer,
  output strobe_t    strb,
  output logic       overflow
);
  localparam int TIMER_W = $clog2(8 * CYC_PER_200NS + 1);
  localparam logic signed [PEND_W:0] P_MAX = (PEND_W + 1)'((1 <<< (PEND_W - 1)) - 1);
  localparam logic signed [PEND_W:0] P_MIN = ~P_MAX;

  logic signed [PEND_W-1:0] pending, pendNext;
  logic signed [PEND_W:0]   inDelta, outDelta, sum;
  logic [TIMER_W-1:0]       timeLeft, reload;
  logic [3:0]               mult;
  logic                     ready, pendNz, ovfSet;

  always_comb begin
    mult   = (mtdCode < 4'd8) ? 4'd1 : mtdCode - 4'd7;
    reload = TIMER_W'(32'(mult) * CYC_PER_200NS);
    ready  = (timeLeft == '0);
    pendNz = (pending != '0);

    strb.emit  = ready && pendNz;
    strb.up    = !pending[PEND_W-1];
    strb.zLoad = ready && !pendNz && zDiffer;

    inDelta = '0;
    if (stepValid) inDelta = stepDir ? (PEND_W + 1)'(1) : '1;
    outDelta = '0;
    if (strb.emit) outDelta = strb.up ? '1 : (PEND_W + 1)'(1);
    sum = (PEND_W + 1)'(pending) + inDelta + outDelta;

    ovfSet   = 1'b0;
    pendNext = sum[PEND_W-1:0];
    if (sum > P_MAX) begin
      pendNext = P_MAX[PEND_W-1:0];
      ovfSet   = 1'b1;
    end else if (sum < P_MIN) begin
      pendNext = P_MIN[PEND_W-1:0];
      ovfSet   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= '0;
      timeLeft <= '0;
      overflow <= 1'b0;
    end else begin
      pending  <= pendNext;
      overflow <= overflow | ovfSet;
      if (strb.emit || strb.zLoad) timeLeft <= reload - TIMER_W'(1);
      else if (!ready)             timeLeft <= timeLeft - TIMER_W'(1);
    end
  end

  // R6
  sat_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> (pending == P_MAX[PEND_W-1:0] || pending == P_MIN[PEND_W-1:0]));

  // R4
  emit_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.emit |=> (timeLeft == $past(reload) - TIMER_W'(1)));

endmodule

// File: rtl/qig_dp.sv
`timescale 1ns/1ps
module qig_dp
  import qig_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strb,
  input  logic       sineZero,
  input  logic [2:0] factorSel,
  input  logic [3:0] quadSel,
  input  logic [7:0] idxPos,
  output logic       a,
  output logic       b,
  output logic       zRaw,
  output logic       zDiffer
);
  logic [6:0] factor, lastPer, period, nextPeriod;
  logic nA, nB, upWrap, downWrap, posEnable;
  logic matchCur, matchNext, zTarget, zNext;

  function automatic logic quadHit(input logic [3:0] sel, input logic qa, input logic qb);
    return (sel[3] & qa & qb) | (sel[2] & qa & ~qb) | (sel[1] & ~qa & ~qb) | (sel[0] & ~qa & qb);
  endfunction

  always_comb begin
    factor  = factorOf(factorSel);
    lastPer = factor - 7'd1;
    nA = strb.up ? ~b : b;
    nB = strb.up ? a : ~a;
    upWrap   = strb.emit && strb.up && !a && b;
    downWrap = strb.emit && !strb.up && !a && !b;
    if (sineZero)      nextPeriod = '0;
    else if (upWrap)   nextPeriod = (period >= lastPer) ? 7'd0 : period + 7'd1;
    else if (downWrap) nextPeriod = (period == 7'd0 || period > lastPer) ? lastPer : period - 7'd1;
    else               nextPeriod = period;
    posEnable = idxPos[7] && (idxPos[6:0] < factor);
    matchCur  = quadHit(quadSel, a, b);
    matchNext = quadHit(quadSel, nA, nB);
    zTarget   = posEnable && (period == idxPos[6:0]) && matchCur;
    zNext     = posEnable && (nextPeriod == idxPos[6:0]) && matchNext;
    zDiffer   = (zTarget != zRaw);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      a      <= 1'b0;
      b      <= 1'b0;
      zRaw   <= 1'b0;
      period <= '0;
    end else begin
      period <= nextPeriod;
      if (strb.emit) begin
        a    <= nA;
        b    <= nB;
        zRaw <= zNext;
      end else if (strb.zLoad) begin
        zRaw <= zTarget;
      end
    end
  end

  // R2
  ab_onestep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !((a != $past(a)) && (b != $past(b))));

  // R4
  ab_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((a != $past(a)) || (b != $past(b))) |-> $past(strb.emit));

  // R4
  z_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (zRaw != $past(zRaw)) |-> $past(strb.emit || strb.zLoad));

endmodule

// File: rtl/quad_index_gen.sv
`timescale 1ns/1ps
module quad_index_gen
  import qig_pkg::*;
#(
  parameter int PEND_W        = 8,
  parameter int CYC_PER_200NS = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepValid,
  input  logic       stepDir,
  input  logic       sineZero,
  input  logic       zeroEn,
  input  logic [2:0] factorSel,
  input  logic [3:0] quadSel,
  input  logic [7:0] idxPos,
  input  logic [3:0] mtdCode,
  output logic       outA,
  output logic       outNA,
  output logic       outB,
  output logic       outNB,
  output logic       outZ,
  output logic       outNZ,
  output logic       overflow
);
  localparam int GAP_W   = $clog2(8 * CYC_PER_200NS + 2);
  localparam int GAP_MAX = 8 * CYC_PER_200NS + 1;

  strobe_t strb;
  logic a, b, zRaw, zDiffer;

  qig_ctrl #(.PEND_W(PEND_W), .CYC_PER_200NS(CYC_PER_200NS)) i_ctrl (
    .clk(clk), .rstN(rstN), .stepValid(stepValid), .stepDir(stepDir),
    .mtdCode(mtdCode), .zDiffer(zDiffer), .strb(strb), .overflow(overflow)
  );

  qig_dp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sineZero(sineZero),
    .factorSel(factorSel), .quadSel(quadSel), .idxPos(idxPos),
    .a(a), .b(b), .zRaw(zRaw), .zDiffer(zDiffer)
  );

  always_comb begin
    outA  = a;
    outNA = ~a;
    outB  = b;
    outNB = ~b;
    outZ  = zRaw & zeroEn;
    outNZ = ~(zRaw & zeroEn);
  end

  // edge spacing monitor for the assertion below
  logic prevA, prevB, abChg;
  logic [GAP_W-1:0] gapCnt;
  assign abChg = (outA != prevA) || (outB != prevB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevA  <= 1'b0;
      prevB  <= 1'b0;
      gapCnt <= GAP_W'(GAP_MAX);
    end else begin
      prevA <= outA;
      prevB <= outB;
      if (abChg)                        gapCnt <= GAP_W'(1);
      else if (gapCnt < GAP_W'(GAP_MAX)) gapCnt <= gapCnt + GAP_W'(1);
    end
  end

  // R4
  min_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    abChg |-> (gapCnt >= GAP_W'(CYC_PER_200NS)));

endmodule

// File: tb/test_quad_index_gen.sv
`timescale 1ns/1ps
module test_quad_index_gen;
  localparam int CYC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stepValid = 1'b0, stepDir = 1'b1, sineZero = 1'b0, zeroEn = 1'b1;
  logic [2:0] factorSel = 3'd0;
  logic [3:0] quadSel = 4'b0010;
  logic [7:0] idxPos = 8'h80;
  logic [3:0] mtdCode = 4'd8;
  logic outA, outNA, outB, outNB, outZ, outNZ, overflow;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  quad_index_gen #(.PEND_W(8), .CYC_PER_200NS(CYC)) i_quad_index_gen (
    .clk(clk), .rstN(rstN), .stepValid(stepValid), .stepDir(stepDir),
    .sineZero(sineZero), .zeroEn(zeroEn), .factorSel(factorSel),
    .quadSel(quadSel), .idxPos(idxPos), .mtdCode(mtdCode),
    .outA(outA), .outNA(outNA), .outB(outB), .outNB(outNB),
    .outZ(outZ), .outNZ(outNZ), .overflow(overflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int abOf(input int c);
    case (c)
      0: return 0;
      1: return 2;
      2: return 3;
      default: return 1;
    endcase
  endfunction

  function automatic int factorTab(input int s);
    case (s)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 5;
      4: return 10;
      5: return 20;
      6: return 25;
      default: return 50;
    endcase
  endfunction

  task automatic checkOut(input string req, input int expAB, input int expZ);
    chk(req, {outA, outB, outZ}, (expAB << 1) | expZ);
    chk("R3", {outNA, outNB, outNZ}, (~{outA, outB, outZ}) & 7);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    stepValid = 1'b0;
    sineZero = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic doStep(input logic up);
    stepValid = 1'b1;
    stepDir = up;
    @(negedge clk);
    stepValid = 1'b0;
    repeat (9) @(negedge clk);
  endtask

  // R7 R8 R9 R10: index sweep, expected Z from step count arithmetic
  task automatic runIdx(input int fs, input int p8, input int q, input logic up, input int nSteps);
    int f;
    f = factorTab(fs);
    factorSel = 3'(fs);
    idxPos = 8'(p8);
    quadSel = 4'(q);
    zeroEn = 1'b1;
    mtdCode = 4'd8;
    doReset();
    sineZero = 1'b1;
    @(negedge clk);
    sineZero = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k <= nSteps; k++) begin
      int c, per, bitIdx, ez;
      if (k > 0) doStep(up);
      if (up) begin
        c = k % 4;
        per = (k / 4) % f;
      end else begin
        c = (4 - (k % 4)) % 4;
        per = (f - (((k + 3) / 4) % f)) % f;
      end
      case (c)
        0: bitIdx = 1;
        1: bitIdx = 2;
        2: bitIdx = 3;
        default: bitIdx = 0;
      endcase
      ez = (((p8 >> 7) & 1) == 1 && (p8 & 127) < f && per == (p8 & 127) && ((q >> bitIdx) & 1) == 1) ? 1 : 0;
      checkOut(up ? "R7 R8 R9 R10 index up" : "R2 R7 index down", abOf(c), ez);
    end
  endtask

  // R4: spacing of a five-step burst
  task automatic runGap(input int code, input int expL);
    int lastEdge, edges, prev, cur;
    mtdCode = 4'(code);
    idxPos = 8'h00;
    doReset();
    lastEdge = -1;
    edges = 0;
    prev = {outA, outB};
    for (int i = 0; i < 5 * expL + 20; i++) begin
      stepValid = (i < 5);
      stepDir = 1'b1;
      @(negedge clk);
      cur = {outA, outB};
      if (cur != prev) begin
        if (lastEdge >= 0) chk("R4 edge gap", i - lastEdge, expL);
        lastEdge = i;
        edges++;
      end
      prev = cur;
    end
    chk("R4 R5 burst edge count", edges, 5);
    checkOut("R5 burst final state", abOf(1), 0);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #900us;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    checkOut("R1 in reset", 0, 0);
    chk("R1 overflow in reset", overflow, 0);
    rstN = 1'b1;
    @(negedge clk);
    quadSel = 4'b0010;
    idxPos = 8'h80;
    factorSel = 3'd2;
    doReset();
    // period counter zero after reset: index at period 0, quadrant AB=00
    checkOut("R1 period zero after reset", 0, 1);

    // R2: up then down sequence, index disabled
    idxPos = 8'h00;
    doReset();
    for (int k = 1; k <= 5; k++) begin
      doStep(1'b1);
      checkOut("R2 up order", abOf(k % 4), 0);
    end
    for (int k = 4; k >= 0; k--) begin
      doStep(1'b0);
      checkOut("R2 down order", abOf(k % 4), 0);
    end

    // index sweeps over every factor
    for (int fs = 0; fs < 8; fs++) begin
      int f;
      f = factorTab(fs);
      runIdx(fs, 8'h80, 4'b0010, 1'b1, 4 * f + 4);
      runIdx(fs, 8'h80 | (f - 1), 4'b1000, 1'b1, 4 * f + 4);
      runIdx(fs, 8'h80 | f, 4'b0100, 1'b1, 4 * f + 4);
      runIdx(fs, (f / 2), 4'b0001, 1'b1, 4 * f + 4);
    end
    runIdx(2, 8'h83, 4'b0010, 1'b0, 20);
    runIdx(3, 8'h81, 4'b1000, 1'b0, 24);

    // R11: zero-track enable gating
    factorSel = 3'd2;
    idxPos = 8'h80;
    quadSel = 4'b0010;
    zeroEn = 1'b1;
    doReset();
    checkOut("R11 enable high", 0, 1);
    zeroEn = 1'b0;
    @(negedge clk);
    checkOut("R11 enable low", 0, 0);
    zeroEn = 1'b1;
    @(negedge clk);
    checkOut("R11 enable back", 0, 1);

    // R4: spacing codes, including an illegal one
    runGap(8, CYC);
    runGap(10, 3 * CYC);
    runGap(15, 8 * CYC);
    runGap(3, CYC);

    // R5: opposite steps cancel in the queue
    mtdCode = 4'd8;
    idxPos = 8'h00;
    doReset();
    for (int i = 0; i < 9; i++) begin
      stepValid = 1'b1;
      stepDir = (i < 7);
      @(negedge clk);
    end
    stepValid = 1'b0;
    repeat (80) @(negedge clk);
    checkOut("R5 net five steps", abOf(1), 0);
    chk("R5 no overflow", overflow, 0);

    // R6: saturation at +127 with the longest spacing
    begin
      int edges, prev, cur;
      mtdCode = 4'd15;
      doReset();
      edges = 0;
      prev = {outA, outB};
      for (int i = 0; i < 200 + 5000; i++) begin
        stepValid = (i < 200);
        stepDir = 1'b1;
        @(negedge clk);
        cur = {outA, outB};
        if (cur != prev) edges++;
        prev = cur;
        if (i == 100) chk("R6 no overflow below limit", overflow, 0);
      end
      chk("R6 sticky overflow", overflow, 1);
      chk("R6 accepted steps", edges, 134);
      checkOut("R6 final state", abOf(134 % 4), 0);
    end

    finishRun();
  end
endmodule